// File: doc/BRIEF.md
# Dual Down-Counting Timer with Masked Interrupt

This block holds two independent down-counters, each with its own reload (divider) register and control register. The control register's low two bits carry an operation code: load, hold or run. Bits [4:2] pick one of eight tick-enable inputs. Each input stands for one source clock rate: code 7 is the fastest (about 100 MHz) and code 5 is 32 MHz. A running counter steps down once for every cycle in which its selected tick enable is high. When it expires, it reloads from its divider and raises its own bit in a shared interrupt status register.

Software reaches the block through a flat 32-bit register port. Writes take effect on a clock edge, and reads return the addressed register combinationally. A single interrupt line is high whenever a status bit is set and its mask bit is also set. Status bits are cleared by writing ones to an acknowledge register. A free-running cycle count is also readable.

Top module: `dual_tick_timer`

## Requirements
- R1: Reset (asynchronous assert, synchronous release) clears all of the following: dividers, counts, control fields, status, mask and the free-running count. It also stops both timers and drives `irq` low.
- R2: A control write with operation 0 (load) copies the divider into the count and leaves the timer stopped. Later ticks do not change the count.
- R3: A control write with operation 1 (hold) freezes the count. The selected tick no longer changes it.
- R4: A control write with operation 2 (run) starts the timer. The rate field in control bits [4:2] selects which `rate_tick` bit decrements the count, and ticks on the other seven bits have no effect. Control readback is {rate, operation} in bits [4:0].
- R5: A control write with operation 3 is ignored: the operation, rate and counting behaviour stay as they were.
- R6: A running timer whose count is 1 or 0 when its tick arrives reloads the divider instead of decrementing. On that same edge it sets its status bit: timer 0 sets bit 0 and timer 1 sets bit 1. A divider of 0 therefore expires on every tick.
- R7: `irq` is high exactly when (status AND mask) is nonzero. The mask is at 0x48, raw status reads at 0x50, and status AND mask reads at 0x54.
- R8: Writing offset 0x4C clears the status bits that are one in the written value. An expiry on the same edge as the acknowledge leaves that bit set.
- R9: The register at 0x38 counts up by one on every clock after reset is released.
- R10: The offsets are as follows. Timer 0 has divider 0x00, count 0x04 and control 0x08. Timer 1 has divider 0x10, count 0x14 and control 0x18. A divider write does not change the count, and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_tick | input | 8 | One tick enable per rate code |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 7 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest case to reach is an expiry that lands on the same edge as an acknowledge write for that timer's status bit. Only in that case does set priority over clear matter. The bench gets there by stepping timer 1 down to a count of 1 with single tick pulses. It then raises the selected tick and the acknowledge write in one cycle, and reads back the status bit. Expiry with a zero divider is reached the same way, as is the rejection of operation code 3 while a timer is held.

// File: rtl/dtt_pkg.sv
package dtt_pkg;
  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_HOLD = 2'd1,
    OP_RUN  = 2'd2,
    OP_BAD  = 2'd3
  } tmr_op_e;

  localparam int unsigned TMR_STRIDE = 16;
  localparam int unsigned OFF_DIV    = 'h00;
  localparam int unsigned OFF_CNT    = 'h04;
  localparam int unsigned OFF_CTRL   = 'h08;
  localparam int unsigned OFF_TIME   = 'h38;
  localparam int unsigned OFF_MASK   = 'h48;
  localparam int unsigned OFF_ACK    = 'h4C;
  localparam int unsigned OFF_STAT   = 'h50;
  localparam int unsigned OFF_MSTAT  = 'h54;
endpackage

// File: rtl/dtt_counter.sv
module dtt_counter
  import dtt_pkg::*;
#(
  parameter int CNT_W     = 32,
  parameter int NUM_RATES = 8,
  localparam int RATE_W   = $clog2(NUM_RATES)
) (
  input  logic                 clk,
  input  logic                 rst_ni,
  input  logic [NUM_RATES-1:0] rate_tick,
  input  logic                 div_wr,
  input  logic [CNT_W-1:0]     div_data,
  input  logic                 ctrl_wr,
  input  logic [1:0]           ctrl_op,
  input  logic [RATE_W-1:0]    ctrl_rate,
  output logic [CNT_W-1:0]     div_o,
  output logic [CNT_W-1:0]     count_o,
  output logic [1:0]           op_o,
  output logic [RATE_W-1:0]    rate_o,
  output logic                 expire_o
);
  logic [CNT_W-1:0]  div_q, div_d;
  logic [CNT_W-1:0]  count_q, count_d;
  tmr_op_e           op_q, op_d;
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              tick_sel;
  logic              running;

  assign tick_sel = rate_tick[rate_q];
  assign running  = (op_q == OP_RUN);
  assign expire_o = running && tick_sel && (count_q <= CNT_W'(1));

  always_comb begin
    div_d   = div_wr ? div_data : div_q;
    count_d = count_q;
    op_d    = op_q;
    rate_d  = rate_q;
    if (running && tick_sel) begin
      count_d = expire_o ? div_q : count_q - CNT_W'(1);
    end
    if (ctrl_wr) begin
      case (tmr_op_e'(ctrl_op))
        OP_LOAD: begin
          count_d = div_q;
          op_d    = OP_LOAD;
          rate_d  = ctrl_rate;
        end
        OP_HOLD: begin
          op_d   = OP_HOLD;
          rate_d = ctrl_rate;
        end
        OP_RUN: begin
          op_d   = OP_RUN;
          rate_d = ctrl_rate;
        end
        default: begin
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      div_q   <= '0;
      count_q <= '0;
      op_q    <= OP_LOAD;
      rate_q  <= '0;
    end else begin
      div_q   <= div_d;
      count_q <= count_d;
      op_q    <= op_d;
      rate_q  <= rate_d;
    end
  end

  assign div_o   = div_q;
  assign count_o = count_q;
  assign op_o    = op_q;
  assign rate_o  = rate_q;

  assert_hold_frozen_R3: assert property (@(posedge clk) disable iff (!rst_ni)
    (op_q != OP_RUN && !ctrl_wr) |=> $stable(count_q));

  assert_bad_op_ignored_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (ctrl_wr && ctrl_op == 2'd3) |=> ($stable(op_q) && $stable(rate_q)));

  assert_expire_reloads_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (expire_o && !ctrl_wr) |=> (count_q == $past(div_q)));
endmodule

// File: rtl/dtt_irq.sv
module dtt_irq #(
  parameter int NUM_SRC = 2
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] set_i,
  input  logic               mask_wr,
  input  logic [NUM_SRC-1:0] mask_bits,
  input  logic               ack_wr,
  input  logic [NUM_SRC-1:0] ack_bits,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] mask_o,
  output logic               irq_o
);
  logic [NUM_SRC-1:0] status_q, status_d;
  logic [NUM_SRC-1:0] mask_q, mask_d;
  logic [NUM_SRC-1:0] clr;

  always_comb begin
    clr      = ack_wr ? ack_bits : '0;
    status_d = (status_q & ~clr) | set_i;
    mask_d   = mask_wr ? mask_bits : mask_q;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= '0;
      mask_q   <= '0;
    end else begin
      status_q <= status_d;
      mask_q   <= mask_d;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & mask_q);

  assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (ack_wr && !(|set_i)) |=> ((status_q & $past(ack_bits)) == '0));

  assert_expiry_sets_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (|set_i) |=> ((status_q & $past(set_i)) == $past(set_i)));
endmodule

// File: rtl/dual_tick_timer.sv
module dual_tick_timer
  import dtt_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int ADDR_W    = 7,
  parameter int NUM_RATES = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] rate_tick,
  input  logic                 bus_wr,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [DATA_W-1:0]    bus_wdata,
  output logic [DATA_W-1:0]    bus_rdata,
  output logic                 irq
);
  localparam int NUM_TIMERS = 2;
  localparam int CNT_W      = DATA_W;
  localparam int RATE_W     = $clog2(NUM_RATES);

  logic [1:0]  rst_sync_q;
  logic        rst_ni;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_ni = rst_sync_q[1];

  logic [CNT_W-1:0]      t_div   [NUM_TIMERS];
  logic [CNT_W-1:0]      t_count [NUM_TIMERS];
  logic [1:0]            t_op    [NUM_TIMERS];
  logic [RATE_W-1:0]     t_rate  [NUM_TIMERS];
  logic [NUM_TIMERS-1:0] t_expire;

  for (genvar g = 0; g < NUM_TIMERS; g++) begin : g_tmr
    logic div_wr, ctrl_wr;
    assign div_wr  = bus_wr && (bus_addr == ADDR_W'(g*TMR_STRIDE + OFF_DIV));
    assign ctrl_wr = bus_wr && (bus_addr == ADDR_W'(g*TMR_STRIDE + OFF_CTRL));
    dtt_counter #(.CNT_W(CNT_W), .NUM_RATES(NUM_RATES)) u_cnt (
      .clk       (clk),
      .rst_ni    (rst_ni),
      .rate_tick (rate_tick),
      .div_wr    (div_wr),
      .div_data  (bus_wdata[CNT_W-1:0]),
      .ctrl_wr   (ctrl_wr),
      .ctrl_op   (bus_wdata[1:0]),
      .ctrl_rate (bus_wdata[RATE_W+1:2]),
      .div_o     (t_div[g]),
      .count_o   (t_count[g]),
      .op_o      (t_op[g]),
      .rate_o    (t_rate[g]),
      .expire_o  (t_expire[g])
    );
  end

  logic                  mask_wr, ack_wr;
  logic [NUM_TIMERS-1:0] status, mask;

  assign mask_wr = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
  assign ack_wr  = bus_wr && (bus_addr == ADDR_W'(OFF_ACK));

  dtt_irq #(.NUM_SRC(NUM_TIMERS)) u_irq (
    .clk       (clk),
    .rst_ni    (rst_ni),
    .set_i     (t_expire),
    .mask_wr   (mask_wr),
    .mask_bits (bus_wdata[NUM_TIMERS-1:0]),
    .ack_wr    (ack_wr),
    .ack_bits  (bus_wdata[NUM_TIMERS-1:0]),
    .status_o  (status),
    .mask_o    (mask),
    .irq_o     (irq)
  );

  logic [DATA_W-1:0] time_q, time_d;
  assign time_d = time_q + DATA_W'(1);

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) time_q <= '0;
    else         time_q <= time_d;
  end

  always_comb begin
    bus_rdata = '0;
    for (int i = 0; i < NUM_TIMERS; i++) begin
      if (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_DIV))  bus_rdata = DATA_W'(t_div[i]);
      if (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_CNT))  bus_rdata = DATA_W'(t_count[i]);
      if (bus_addr == ADDR_W'(i*TMR_STRIDE + OFF_CTRL)) bus_rdata = DATA_W'({t_rate[i], t_op[i]});
    end
    if (bus_addr == ADDR_W'(OFF_TIME))  bus_rdata = time_q;
    if (bus_addr == ADDR_W'(OFF_MASK))  bus_rdata = DATA_W'(mask);
    if (bus_addr == ADDR_W'(OFF_STAT))  bus_rdata = DATA_W'(status);
    if (bus_addr == ADDR_W'(OFF_MSTAT)) bus_rdata = DATA_W'(status & mask);
  end

  assert_time_steps_R9: assert property (@(posedge clk) disable iff (!rst_ni)
    rst_ni |=> (time_q == $past(time_q) + DATA_W'(1)));

  assert_irq_quiet_in_reset_R1: assert property (@(posedge clk)
    (!rst_ni) |-> !irq);
endmodule

// File: tb/dual_tick_timer_test.sv
module dual_tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  rate_tick = '0;
  logic        bus_wr = 1'b0;
  logic [6:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dual_tick_timer uut (
    .clk(clk), .rst_n(rst_n), .rate_tick(rate_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: %s got %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [6:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [6:0] a, input logic [31:0] exp, input string req);
    bus_addr = a;
    #1;
    check(req, $sformatf("read 0x%h", a), bus_rdata, exp);
  endtask

  task automatic tick(input int r);
    @(negedge clk);
    rate_tick = 8'(1 << r);
    @(negedge clk);
    rate_tick = '0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset_state();
    rd(7'h00, 0, "R1"); rd(7'h04, 0, "R1"); rd(7'h08, 0, "R1");
    rd(7'h50, 0, "R1"); rd(7'h48, 0, "R1"); rd(7'h54, 0, "R1");
    check("R1", "irq", 32'(irq), 0);
  endtask

  task automatic t_load_run();
    wr(7'h00, 3);
    rd(7'h04, 0, "R10");
    rd(7'h00, 3, "R10");
    wr(7'h08, 32'h14);          // load, rate 5
    rd(7'h04, 3, "R2");
    tick(5);
    rd(7'h04, 3, "R2");
    wr(7'h08, 32'h16);          // run, rate 5
    rd(7'h08, 32'h16, "R4");
    tick(5);
    rd(7'h04, 2, "R4");
    tick(7);
    rd(7'h04, 2, "R4");
    tick(4);
    rd(7'h04, 2, "R4");
  endtask

  task automatic t_expire();
    tick(5);
    rd(7'h04, 1, "R6");
    rd(7'h50, 0, "R6");
    tick(5);
    rd(7'h04, 3, "R6");
    rd(7'h50, 1, "R6");
    check("R7", "irq masked off", 32'(irq), 0);
    rd(7'h54, 0, "R7");
    wr(7'h48, 1);
    check("R7", "irq after mask", 32'(irq), 1);
    rd(7'h54, 1, "R7");
  endtask

  task automatic t_ack();
    wr(7'h4C, 2);
    rd(7'h50, 1, "R8");
    wr(7'h4C, 1);
    rd(7'h50, 0, "R8");
    check("R8", "irq after ack", 32'(irq), 0);
  endtask

  task automatic t_hold_bad();
    wr(7'h08, 32'h15);          // hold, rate 5
    tick(5);
    rd(7'h04, 3, "R3");
    wr(7'h08, 32'h1F);          // op 3, rate 7
    rd(7'h08, 32'h15, "R5");
    tick(5);
    rd(7'h04, 3, "R5");
    wr(7'h08, 32'h16);
    tick(5);
    rd(7'h04, 2, "R4");
  endtask

  task automatic t_timer1();
    wr(7'h10, 2);
    wr(7'h18, 32'h00);
    rd(7'h14, 2, "R10");
    wr(7'h18, 32'h1E);          // run, rate 7
    tick(7);
    rd(7'h14, 1, "R4");
    rd(7'h04, 2, "R4");
    tick(7);
    rd(7'h14, 2, "R6");
    rd(7'h50, 2, "R6");
    check("R7", "irq bit1 unmasked-off", 32'(irq), 0);
    wr(7'h48, 3);
    check("R7", "irq bit1", 32'(irq), 1);
    rd(7'h54, 2, "R7");
  endtask

  task automatic t_race();
    wr(7'h4C, 2);
    rd(7'h50, 0, "R8");
    tick(7);
    rd(7'h14, 1, "R8");
    @(negedge clk);
    rate_tick = 8'h80; bus_wr = 1'b1; bus_addr = 7'h4C; bus_wdata = 2;
    @(negedge clk);
    rate_tick = '0; bus_wr = 1'b0; bus_wdata = '0;
    rd(7'h50, 2, "R8");
    wr(7'h4C, 2);
    rd(7'h50, 0, "R8");
  endtask

  task automatic t_div_zero();
    wr(7'h00, 0);
    wr(7'h08, 32'h14);
    rd(7'h04, 0, "R6");
    wr(7'h08, 32'h16);
    tick(5);
    rd(7'h50, 1, "R6");
    rd(7'h04, 0, "R6");
    wr(7'h4C, 1);
    rd(7'h50, 0, "R6");
    tick(5);
    rd(7'h50, 1, "R6");
    wr(7'h4C, 1);
  endtask

  task automatic t_time_unmapped();
    logic [31:0] t0, t1;
    bus_addr = 7'h38; #1; t0 = bus_rdata;
    repeat (10) @(negedge clk);
    #1; t1 = bus_rdata;
    check("R9", "time delta", t1 - t0, 10);
    rd(7'h20, 0, "R10");
    rd(7'h3C, 0, "R10");
  endtask

  task automatic t_mid_reset();
    wr(7'h00, 5);
    wr(7'h08, 32'h14);
    wr(7'h08, 32'h16);
    wr(7'h48, 3);
    tick(5);
    rd(7'h04, 4, "R1");
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1", "irq in reset", 32'(irq), 0);
    rd(7'h48, 0, "R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    rd(7'h04, 0, "R1"); rd(7'h00, 0, "R1"); rd(7'h08, 0, "R1");
    rd(7'h50, 0, "R1"); rd(7'h48, 0, "R1");
    tick(5);
    rd(7'h04, 0, "R1");
    rd(7'h50, 0, "R1");
  endtask

  initial begin
    do_reset();
    t_reset_state();
    t_load_run();
    t_expire();
    t_ack();
    t_hold_bad();
    t_timer1();
    t_race();
    t_div_zero();
    t_time_unmapped();
    t_mid_reset();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule